// File: doc/BRIEF.md
# Power-Good Strap Latch Controller

This block takes a snapshot of the three frequency-select straps and the debug-enable strap at power-up. It takes the snapshot at the first moment the power-good strobe is seen high and stable. From the captured frequency bits it produces a CPU clock frequency index. From the captured debug strap it chooses the function of a shared differential output pair: a CPU clock or a serial reference clock.

Once the snapshot is taken, the strobe pin takes on a second role: a live, active-low power-down request. A low on the pin before the snapshot only means power is not yet good, so it raises no request. Outside test mode the snapshot is taken once and later changes are ignored. In test mode every stable-high sample of the strobe refreshes the snapshot. The live middle frequency strap then chooses between a high-impedance output and a divided reference output.

All inputs pass through a two-stage synchronizer. All outputs are registered.

Top module: `strap_latch_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, every output is 0.
- R2: A capture happens only after the synchronized power-good input has been high in two consecutive cycles. A high pulse lasting a single clock period causes no capture. After a capture `straps_valid` is 1 and `fs_latched` holds {fs_c, fs_b, fs_a} as sampled.
- R3: `freq_idx` encodes the CPU frequency as 0=100, 1=133, 2=166, 3=200, 4=266, 5=333, 6=400 MHz. Captured {c,b,a} maps as follows: 000→266, 001→133, 010→200, 011→166, 100→333, 101→100, 110→400.
- R4: Captured code 111 sets `freq_rsvd` to 1 and gives `freq_idx` = 0 (100 MHz). Every other code gives `freq_rsvd` = 0.
- R5: With test mode low, changes on the frequency straps, the debug strap or the power-good pin after capture leave `fs_latched`, `freq_idx`, `freq_rsvd` and `sel_cpu2` unchanged.
- R6: `sel_cpu2` is the captured debug-enable strap. A value of 1 selects the CPU clock function on the shared pair, and 0 selects the serial reference function.
- R7: `pdn_req` is 1 exactly when a capture has occurred and the synchronized power-good pin is low. Before capture it stays 0 for any pin level.
- R8: While synchronized test mode is high, every cycle in which power-good is valid high refreshes all captured values.
- R9: While synchronized test mode is high, `tm_hiz` equals the inverse of the live fs_b and `tm_refdiv` equals fs_b. Outside test mode both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fs_a_in | input | 1 | Frequency strap A (asynchronous) |
| fs_b_in | input | 1 | Frequency strap B; also selects the test-mode output behaviour |
| fs_c_in | input | 1 | Frequency strap C |
| dbg_en_in | input | 1 | Debug-enable strap choosing the shared-pair function |
| test_mode_in | input | 1 | Test-mode qualifier |
| pwrgd_in | input | 1 | Power-good strobe; acts as the active-low power-down input after capture |
| straps_valid | output | 1 | Capture has occurred |
| fs_latched | output | 3 | Captured {c,b,a} |
| sel_cpu2 | output | 1 | 1 = CPU clock on the shared pair, 0 = serial reference clock |
| freq_idx | output | 3 | Decoded CPU frequency index |
| freq_rsvd | output | 1 | Captured code is the reserved 111 |
| pdn_req | output | 1 | Power-down request |
| tm_hiz | output | 1 | Test mode: outputs high impedance |
| tm_refdiv | output | 1 | Test mode: outputs carry the divided reference |

## Verification
The bench drives a single-period power-good pulse. A design that skipped the stability filter would capture on that glitch. It toggles the pin low before capture, where a careless design would raise a false power-down, and it moves the straps and the strobe after capture to catch a latch that keeps following its inputs. It sweeps all eight codes after fresh resets, so a swapped decode entry or a missing reserved flag shows up. It then changes straps in test mode, where a strictly one-shot latch would fail to refresh and would keep driving the test-output selects after test mode ends.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int FS_W  = 3;
  localparam int IDX_W = 3;

  typedef enum logic [IDX_W-1:0] {
    FREQ_100 = 3'd0,
    FREQ_133 = 3'd1,
    FREQ_166 = 3'd2,
    FREQ_200 = 3'd3,
    FREQ_266 = 3'd4,
    FREQ_333 = 3'd5,
    FREQ_400 = 3'd6
  } freq_e;
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign d_out = stg[STAGES-1];
endmodule

// File: rtl/strap_freq_decode.sv
module strap_freq_decode
  import strap_pkg::*;
(
  input  logic [FS_W-1:0] code,
  output freq_e           idx,
  output logic            rsvd
);
  always_comb begin
    rsvd = 1'b0;
    unique case (code)
      3'b000: idx = FREQ_266;
      3'b001: idx = FREQ_133;
      3'b010: idx = FREQ_200;
      3'b011: idx = FREQ_166;
      3'b100: idx = FREQ_333;
      3'b101: idx = FREQ_100;
      3'b110: idx = FREQ_400;
      default: begin
        idx  = FREQ_100;
        rsvd = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            pg_s,
  input  logic            tm_s,
  input  logic            dbg_s,
  input  logic [FS_W-1:0] fs_s,
  input  freq_e           dec_idx,
  input  logic            dec_rsvd,
  output logic            captured,
  output logic [FS_W-1:0] fs_lat,
  output logic            dbg_lat,
  output logic [IDX_W-1:0] idx_lat,
  output logic            rsvd_lat,
  output logic            pdn,
  output logic            hiz,
  output logic            refdiv
);
  logic pg_d;
  logic valid_hi;
  logic take;

  assign valid_hi = pg_s & pg_d;
  assign take     = valid_hi & (~captured | tm_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      pg_d     <= 1'b0;
      captured <= 1'b0;
      fs_lat   <= '0;
      dbg_lat  <= 1'b0;
      idx_lat  <= '0;
      rsvd_lat <= 1'b0;
      pdn      <= 1'b0;
      hiz      <= 1'b0;
      refdiv   <= 1'b0;
    end else begin
      pg_d <= pg_s;
      if (take) begin
        captured <= 1'b1;
        fs_lat   <= fs_s;
        dbg_lat  <= dbg_s;
        idx_lat  <= dec_idx;
        rsvd_lat <= dec_rsvd;
      end
      pdn    <= captured & ~pg_s;
      hiz    <= tm_s & ~fs_s[1];
      refdiv <= tm_s & fs_s[1];
    end
  end

  // R7
  pdn_no_early_chk: assert property (@(posedge clk) disable iff (rst)
    !captured |-> !pdn);

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(captured) && !$past(tm_s)) |-> ($stable(fs_lat) && $stable(dbg_lat) && $stable(idx_lat)));

  // R2
  capture_needs_pg_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(captured) |-> ($past(pg_s) && $past(pg_d)));

  // R4
  rsvd_idx_chk: assert property (@(posedge clk) disable iff (rst)
    rsvd_lat |-> (idx_lat == IDX_W'(FREQ_100)));

  // R9
  tm_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(hiz && refdiv));
endmodule

// File: rtl/strap_latch_ctrl.sv
module strap_latch_ctrl
  import strap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fs_a_in,
  input  logic             fs_b_in,
  input  logic             fs_c_in,
  input  logic             dbg_en_in,
  input  logic             test_mode_in,
  input  logic             pwrgd_in,
  output logic             straps_valid,
  output logic [FS_W-1:0]  fs_latched,
  output logic             sel_cpu2,
  output logic [IDX_W-1:0] freq_idx,
  output logic             freq_rsvd,
  output logic             pdn_req,
  output logic             tm_hiz,
  output logic             tm_refdiv
);
  localparam int SW = FS_W + 3;

  logic [SW-1:0]   raw_v, syn_v;
  logic [FS_W-1:0] fs_s;
  logic            dbg_s, tm_s, pg_s;
  freq_e           dec_idx;
  logic            dec_rsvd;

  assign raw_v = {pwrgd_in, test_mode_in, dbg_en_in, fs_c_in, fs_b_in, fs_a_in};
  assign fs_s  = syn_v[FS_W-1:0];
  assign dbg_s = syn_v[FS_W];
  assign tm_s  = syn_v[FS_W+1];
  assign pg_s  = syn_v[FS_W+2];

  strap_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (raw_v),
    .d_out (syn_v)
  );

  strap_freq_decode u_dec (
    .code (fs_s),
    .idx  (dec_idx),
    .rsvd (dec_rsvd)
  );

  strap_capture u_cap (
    .clk      (clk),
    .rst      (rst),
    .pg_s     (pg_s),
    .tm_s     (tm_s),
    .dbg_s    (dbg_s),
    .fs_s     (fs_s),
    .dec_idx  (dec_idx),
    .dec_rsvd (dec_rsvd),
    .captured (straps_valid),
    .fs_lat   (fs_latched),
    .dbg_lat  (sel_cpu2),
    .idx_lat  (freq_idx),
    .rsvd_lat (freq_rsvd),
    .pdn      (pdn_req),
    .hiz      (tm_hiz),
    .refdiv   (tm_refdiv)
  );
endmodule

// File: tb/test_strap_latch_ctrl.sv
module test_strap_latch_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fs_a = 0, fs_b = 0, fs_c = 0, dbg = 0, tm = 0, pg = 0;
  logic       straps_valid, sel_cpu2, freq_rsvd, pdn_req, tm_hiz, tm_refdiv;
  logic [2:0] fs_latched, freq_idx;

  always #4 clk = ~clk;

  strap_latch_ctrl i_strap_latch_ctrl (
    .clk(clk), .rst(rst), .fs_a_in(fs_a), .fs_b_in(fs_b), .fs_c_in(fs_c),
    .dbg_en_in(dbg), .test_mode_in(tm), .pwrgd_in(pg),
    .straps_valid(straps_valid), .fs_latched(fs_latched), .sel_cpu2(sel_cpu2),
    .freq_idx(freq_idx), .freq_rsvd(freq_rsvd), .pdn_req(pdn_req),
    .tm_hiz(tm_hiz), .tm_refdiv(tm_refdiv)
  );

  typedef struct {
    string      tag;
    logic [9:0] v; // valid,fs[3],sel,idx[3],rsvd,pdn
    logic [1:0] t; // hiz,refdiv
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // R3 / R4 mapping, from the requirement table
  function automatic logic [3:0] ref_dec(input logic [2:0] c);
    case (c)
      3'b000: return {1'b0, 3'd4};
      3'b001: return {1'b0, 3'd1};
      3'b010: return {1'b0, 3'd3};
      3'b011: return {1'b0, 3'd2};
      3'b100: return {1'b0, 3'd5};
      3'b101: return {1'b0, 3'd0};
      3'b110: return {1'b0, 3'd6};
      default: return {1'b1, 3'd0};
    endcase
  endfunction

  task automatic push(input string tag, input logic vld, input logic [2:0] f,
                      input logic s, input logic p, input logic h, input logic r);
    exp_t e;
    logic [3:0] d;
    d = vld ? ref_dec(f) : 4'd0;
    e.tag = tag;
    e.v = {vld, vld ? f : 3'd0, vld ? s : 1'b0, d[2:0], d[3], p};
    e.t = {h, r};
    q.push_back(e);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; pg = 0; tm = 0;
    settle(3);
    rst = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      exp_t e;
      logic [9:0] av;
      logic [1:0] at;
      wait (q.size() != 0);
      e = q.pop_front();
      #1;
      av = {straps_valid, fs_latched, sel_cpu2, freq_idx, freq_rsvd, pdn_req};
      at = {tm_hiz, tm_refdiv};
      checks++;
      if (av !== e.v || at !== e.t) begin
        errors++;
        $display("FAIL %s: got %b/%b expected %b/%b", e.tag, av, at, e.v, e.t);
      end
    end
  end

  // driver
  initial begin
    settle(2);
    push("R1 in reset", 0, 0, 0, 0, 0, 0);
    rst = 1'b0;
    push("R1 after reset", 0, 0, 0, 0, 0, 0);
    settle(1);
    fs_c = 0; fs_b = 1; fs_a = 0; dbg = 1;
    settle(6);
    push("R7 low before capture no pdn", 0, 0, 0, 0, 0, 0);
    pg = 1; settle(1); pg = 0;
    settle(6);
    push("R2 one-period pulse ignored", 0, 0, 0, 0, 0, 0);
    pg = 1; settle(6);
    push("R2 R3 R6 capture 010 dbg1", 1, 3'b010, 1, 0, 0, 0);
    fs_c = 1; fs_b = 1; fs_a = 1; dbg = 0; settle(6);
    push("R5 straps ignored after capture", 1, 3'b010, 1, 0, 0, 0);
    pg = 0; settle(6);
    push("R7 pdn asserted on low", 1, 3'b010, 1, 1, 0, 0);
    pg = 1; settle(6);
    push("R7 R5 pdn released, hold", 1, 3'b010, 1, 0, 0, 0);

    for (int c = 0; c < 8; c++) begin
      do_reset();
      {fs_c, fs_b, fs_a} = 3'(c);
      dbg = c[0];
      settle(1);
      pg = 1; settle(6);
      push(c == 7 ? "R4 reserved code" : "R3 R6 decode sweep", 1, 3'(c), c[0], 0, 0, 0);
    end

    do_reset();
    tm = 1; {fs_c, fs_b, fs_a} = 3'b101; dbg = 0;
    settle(1);
    pg = 1; settle(6);
    push("R8 R9 test capture hiz", 1, 3'b101, 0, 0, 1, 0);
    {fs_c, fs_b, fs_a} = 3'b110; dbg = 1; settle(6);
    push("R8 R9 test refresh refdiv", 1, 3'b110, 1, 0, 0, 1);
    tm = 0; settle(6);
    push("R9 test selects cleared", 1, 3'b110, 1, 0, 0, 0);
    {fs_c, fs_b, fs_a} = 3'b001; dbg = 0; settle(6);
    push("R5 hold after leaving test", 1, 3'b110, 1, 0, 0, 0);

    wait (q.size() == 0);
    settle(2);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule